// File: doc/BRIEF.md
# Control Register Read-Modify-Write Unit

This unit carries out the three control-register access operations of a processor core: swap, set bits and clear bits. All three go through one path. Each operation is turned into a new-data word and a write mask. The addressed register then takes `(old & ~mask) | (data & mask)`, and the value it held before the request is returned. A set or clear issued without a named source register has a zero mask, so it only reads.

The unit holds a small bank of registers, each with an access attribute. The attribute gives the minimum privilege level needed and whether the register is read-only. A request that names an unknown register, lacks privilege, uses the reserved operation code, or tries to change a read-only register is refused. The refusal is reported on an error output, which the core turns into an illegal-instruction exception. A request is presented for one cycle, and its response appears on registered outputs in the following cycle.

Top module: `csr_rmw_unit`

## Requirements
- R1: Swap (`req_op` = 2'b01) writes `req_src` into the register whole, whatever the state of `req_src_named`, and returns the previous contents.
- R2: Set (`req_op` = 2'b10) with `req_src_named` = 1 ORs `req_src` into the register and returns the previous contents.
- R3: Clear (`req_op` = 2'b11) with `req_src_named` = 1 clears the register bits that are 1 in `req_src` and returns the previous contents.
- R4: Set or clear with `req_src_named` = 0 leaves the register unchanged and keeps `rsp_wr` low. It returns the contents, and it does not fail even on a read-only register.
- R5: `rsp_wr` is high exactly when an accepted request had a nonzero mask. A named set or clear with `req_src` = 0 returns data with `rsp_wr` low. A register not addressed by an accepted write keeps its value.
- R6: The index is laid out as follows. Bits [7:0] select slot k. Bits [11:8] must equal that slot's 4-bit attribute, where slot k's attribute is bits [4k+3:4k] of `ACCESS_ATTR`. The default table, slot 0 to slot 7, is 0, 1, 3, C, F, 5, B, 0 (hex). A slot number of `NUM_REGS` or more, a mismatched attribute, or `req_op` = 2'b00 gives `rsp_err` = 1, `rsp_rdata` = 0 and no write.
- R7: A request whose `priv_lvl` is below index bits [9:8] fails, with the same response as in R6.
- R8: Index bits [11:10] = 2'b11 mark a read-only register. Any nonzero-mask request to it fails, while zero-mask reads succeed.
- R9: `rsp_valid` is high in exactly the cycle after each cycle with `req_valid` high. `rsp_err` and `rsp_wr` are never high together.
- R10: After reset, register k holds the 4-bit value k repeated across the word, for example 32'h33333333 for slot 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_op | input | 2 | 01 swap, 10 set, 11 clear, 00 reserved |
| req_idx | input | 12 | Register index: [7:0] slot, [9:8] minimum privilege, [11:10] access class |
| req_src | input | XLEN | Source operand |
| req_src_named | input | 1 | A source register was named in the instruction |
| priv_lvl | input | 2 | Current privilege level |
| rsp_valid | output | 1 | Response strobe |
| rsp_rdata | output | XLEN | Register contents before the write, 0 on error |
| rsp_wr | output | 1 | The request changed the register |
| rsp_err | output | 1 | Request refused; raise illegal instruction |

## Verification
The assertions check several properties on every cycle:
- the one-cycle response timing;
- that an error never comes with a write strobe or nonzero data;
- that no write reaches a read-only register;
- that every register not targeted by an accepted write holds its value.

Only the bench's sweep can show the arithmetic results of swap, set and clear, the attribute and privilege decisions for each slot, and the reset contents. The sweep covers every slot, privilege level, operation code and source-named setting, and checks each response against a model kept in the bench.

// File: rtl/csr_rmw_pkg.sv
package csr_rmw_pkg;
  typedef enum logic [1:0] {
    OP_RSVD = 2'b00,
    OP_SWAP = 2'b01,
    OP_SET  = 2'b10,
    OP_CLR  = 2'b11
  } csr_op_e;

  localparam int IDX_W      = 12;
  localparam int SLOT_FLD_W = 8;
  localparam int ATTR_W     = 4;
endpackage

// File: rtl/csr_rmw_mask_gen.sv
module csr_rmw_mask_gen
  import csr_rmw_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [1:0]      op,
  input  logic [XLEN-1:0] src,
  input  logic            src_named,
  output logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] wmask,
  output logic            op_ok
);
  always_comb begin
    wdata = '0;
    wmask = '0;
    op_ok = 1'b1;
    case (csr_op_e'(op))
      OP_SWAP: begin
        wdata = src;
        wmask = '1;
      end
      OP_SET: begin
        wdata = '1;
        wmask = src_named ? src : '0;
      end
      OP_CLR: begin
        wdata = '0;
        wmask = src_named ? src : '0;
      end
      default: op_ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/csr_rmw_access_chk.sv
module csr_rmw_access_chk
  import csr_rmw_pkg::*;
#(
  parameter int                      NUM_REGS    = 8,
  parameter int                      SLOT_W      = 3,
  parameter logic [NUM_REGS*4-1:0]   ACCESS_ATTR = '0
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic [1:0]        priv,
  input  logic              mask_nz,
  input  logic              op_ok,
  output logic [SLOT_W-1:0] slot,
  output logic              is_ro,
  output logic              fault
);
  logic [SLOT_FLD_W-1:0] fld;
  logic [ATTR_W-1:0]     attr;
  logic                  hit;

  assign fld   = idx[SLOT_FLD_W-1:0];
  assign slot  = fld[SLOT_W-1:0];
  assign is_ro = (idx[11:10] == 2'b11);

  always_comb begin
    attr = '0;
    hit  = 1'b0;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (fld == SLOT_FLD_W'(k)) begin
        attr = ACCESS_ATTR[k*ATTR_W +: ATTR_W];
        hit  = 1'b1;
      end
    end
  end

  always_comb begin
    fault = 1'b0;
    if (!op_ok)                     fault = 1'b1;
    else if (!hit)                  fault = 1'b1;
    else if (idx[11:8] != attr)     fault = 1'b1;
    else if (priv < idx[9:8])       fault = 1'b1;
    else if (is_ro && mask_nz)      fault = 1'b1;
  end
endmodule

// File: rtl/csr_rmw_bank.sv
module csr_rmw_bank #(
  parameter int NUM_REGS = 8,
  parameter int XLEN     = 32,
  parameter int SLOT_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [XLEN-1:0]   rd_data,
  input  logic              we,
  input  logic [XLEN-1:0]   wdata,
  input  logic [XLEN-1:0]   wmask
);
  logic [XLEN-1:0] regs [NUM_REGS];
  logic [XLEN-1:0] commit;

  assign rd_data = regs[rd_slot];
  assign commit  = (rd_data & ~wmask) | (wdata & wmask);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NUM_REGS; k++) regs[k] <= {(XLEN/4){4'(k)}};
    end else if (we) begin
      regs[rd_slot] <= commit;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_hold
    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
      !(we && rd_slot == SLOT_W'(g)) |=> $stable(regs[g]))
      else $error("slot %0d changed without a write", g);
  end
endmodule

// File: rtl/csr_rmw_unit.sv
module csr_rmw_unit
  import csr_rmw_pkg::*;
#(
  parameter int                    XLEN        = 32,
  parameter int                    NUM_REGS    = 8,
  parameter logic [NUM_REGS*4-1:0] ACCESS_ATTR = 32'h0B5FC310
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [1:0]       req_op,
  input  logic [11:0]      req_idx,
  input  logic [XLEN-1:0]  req_src,
  input  logic             req_src_named,
  input  logic [1:0]       priv_lvl,
  output logic             rsp_valid,
  output logic [XLEN-1:0]  rsp_rdata,
  output logic             rsp_wr,
  output logic             rsp_err
);
  localparam int SLOT_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [XLEN-1:0]   wdata, wmask, old_val;
  logic              op_ok, mask_nz, fault, is_ro, bank_we;
  logic [SLOT_W-1:0] slot;

  csr_rmw_mask_gen #(.XLEN(XLEN)) mask_i (
    .op(req_op), .src(req_src), .src_named(req_src_named),
    .wdata(wdata), .wmask(wmask), .op_ok(op_ok)
  );

  assign mask_nz = |wmask;

  csr_rmw_access_chk #(.NUM_REGS(NUM_REGS), .SLOT_W(SLOT_W), .ACCESS_ATTR(ACCESS_ATTR)) chk_i (
    .idx(req_idx), .priv(priv_lvl), .mask_nz(mask_nz), .op_ok(op_ok),
    .slot(slot), .is_ro(is_ro), .fault(fault)
  );

  assign bank_we = req_valid && !fault && mask_nz;

  csr_rmw_bank #(.NUM_REGS(NUM_REGS), .XLEN(XLEN), .SLOT_W(SLOT_W)) bank_i (
    .clk(clk), .rst(rst), .rd_slot(slot), .rd_data(old_val),
    .we(bank_we), .wdata(wdata), .wmask(wmask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_wr    <= 1'b0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= (req_valid && !fault) ? old_val : '0;
      rsp_wr    <= bank_we;
      rsp_err   <= req_valid && fault;
    end
  end

  assert_latency_R9: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid) else $error("response missing");
  assert_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid) else $error("spurious response");
  assert_excl_R9: assert property (@(posedge clk) disable iff (rst)
    !(rsp_err && rsp_wr)) else $error("error with write strobe");
  assert_errdata_R6: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (rsp_rdata == '0) && rsp_valid) else $error("error response carries data");
  assert_ro_guard_R8: assert property (@(posedge clk) disable iff (rst)
    bank_we |-> !is_ro) else $error("write to read-only register");
  assert_strobe_R5: assert property (@(posedge clk) disable iff (rst)
    rsp_wr |-> rsp_valid) else $error("write strobe without response");
endmodule

// File: tb/csr_rmw_unit_tb.sv
module csr_rmw_unit_tb_top;
  localparam int XLEN = 32;
  localparam int NREG = 8;
  localparam logic [31:0] ATTR = 32'h0B5FC310;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [1:0] req_op = '0;
  logic [11:0] req_idx = '0;
  logic [XLEN-1:0] req_src = '0;
  logic req_src_named = 1'b0;
  logic [1:0] priv_lvl = '0;
  logic rsp_valid, rsp_wr, rsp_err;
  logic [XLEN-1:0] rsp_rdata;

  int checks = 0;
  int fails = 0;
  logic [XLEN-1:0] model [NREG];

  always #10 clk = ~clk;

  csr_rmw_unit #(.XLEN(XLEN), .NUM_REGS(NREG), .ACCESS_ATTR(ATTR)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .req_idx(req_idx),
    .req_src(req_src), .req_src_named(req_src_named), .priv_lvl(priv_lvl),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_wr(rsp_wr), .rsp_err(rsp_err)
  );

  task automatic check(input string tag, input logic [XLEN+2:0] act, input logic [XLEN+2:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {valid,err,wr,rdata} actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drives one request at a falling edge, checks the response one falling edge later.
  task automatic issue(input logic [1:0] op, input logic [11:0] idx, input logic [XLEN-1:0] src,
                       input logic named, input logic [1:0] pl);
    int slot;
    logic exists, err, wr;
    logic [XLEN-1:0] mask, nv, exp_d;
    string tag;
    slot   = int'(idx[7:0]);
    exists = (slot < NREG) && (idx[11:8] == ATTR[slot*4 +: 4]);
    mask   = (op == 2'b01) ? '1 : (named ? src : '0);
    nv     = (op == 2'b01) ? src : ((op == 2'b10) ? '1 : '0);
    err    = (op == 2'b00) || !exists || (pl < idx[9:8]) || (idx[11:10] == 2'b11 && mask != 0);
    wr     = !err && (mask != 0);
    exp_d  = err ? '0 : model[slot];
    if (op == 2'b00 || !exists)                 tag = "R6 unknown/reserved";
    else if (pl < idx[9:8])                     tag = "R7 privilege";
    else if (idx[11:10] == 2'b11 && mask != 0)  tag = "R8 read-only";
    else if (!named && op != 2'b01)             tag = "R4 unnamed source";
    else if (mask == 0)                         tag = "R5 zero mask";
    else if (op == 2'b01)                       tag = "R1 swap";
    else if (op == 2'b10)                       tag = "R2 set";
    else                                        tag = "R3 clear";
    req_valid = 1'b1; req_op = op; req_idx = idx; req_src = src;
    req_src_named = named; priv_lvl = pl;
    @(negedge clk);
    req_valid = 1'b0;
    check(tag, {rsp_valid, rsp_err, rsp_wr, rsp_rdata}, {1'b1, err, wr, exp_d});
    if (wr) model[slot] = (model[slot] & ~mask) | (nv & mask);
  endtask

  function automatic logic [11:0] good_idx(input int k);
    return {ATTR[k*4 +: 4], 8'(k)};
  endfunction

  initial begin
    #(20 * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int k = 0; k < NREG; k++) model[k] = {(XLEN/4){4'(k)}};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R9 idle after reset", {rsp_valid, rsp_err, rsp_wr, rsp_rdata}, '0);
    // R10: reset contents read through zero-mask set at top privilege
    for (int k = 0; k < NREG; k++) begin
      checks++;
      issue(2'b10, good_idx(k), 32'hFFFF_FFFF, 1'b0, 2'd3);
      checks--;
      if (rsp_rdata !== {(XLEN/4){4'(k)}}) begin
        checks++; fails++;
        $display("FAIL R10 reset slot %0d: actual %h expected %h", k, rsp_rdata, {(XLEN/4){4'(k)}});
      end else checks++;
    end
    // Sweep every slot, privilege, operation and source-named flag.
    for (int k = 0; k < NREG; k++)
      for (int p = 0; p < 4; p++)
        for (int op = 0; op < 4; op++)
          for (int n = 0; n < 2; n++) begin
            logic [XLEN-1:0] s;
            s = ((k + p + op + n) % 5 == 0) ? '0 : (32'h9E37_79B9 * (k * 32 + p * 8 + op * 2 + n + 1));
            issue(2'(op), good_idx(k), s, n[0], 2'(p));
          end
    // R6: unknown slots and mismatched attributes
    issue(2'b01, 12'h008, 32'h1234_5678, 1'b1, 2'd3);
    issue(2'b10, 12'hFFF, 32'h0000_00FF, 1'b1, 2'd3);
    issue(2'b10, 12'h002, 32'h0000_0001, 1'b0, 2'd3);
    issue(2'b11, 12'h100, 32'h0000_0001, 1'b1, 2'd3);
    // Back-to-back accesses to one register: each sees the previous write.
    issue(2'b01, good_idx(0), 32'hDEAD_BEEF, 1'b1, 2'd0);
    issue(2'b11, good_idx(0), 32'h0000_FFFF, 1'b1, 2'd0);
    issue(2'b10, good_idx(0), 32'h0000_0F00, 1'b1, 2'd0);
    issue(2'b10, good_idx(0), 32'h0, 1'b0, 2'd0);
    // R9: no response in a cycle without a request.
    @(negedge clk);
    check("R9 idle", {rsp_valid, rsp_err, rsp_wr, rsp_rdata}, '0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule